// File: doc/BRIEF.md
# Programmable AND-OR Array

This block is a configurable two-level logic array. Sixteen array inputs feed sixty-four product terms. Each product term is built from any chosen subset of the 32 literals, which are the true and complemented forms of every array input. Ten array inputs come from dedicated input pins. The other six are read back from bidirectional pads. Eight outputs leave the block. Outputs 0 to 5 drive the bidirectional pads and outputs 6 and 7 drive output-only pads. Each output owns eight product terms. Seven of them are ORed and the result is inverted onto the pad value. The eighth product term drives that pad's enable.

The connection map is held in a 2048-bit fuse chain. It is loaded serially: while `cfg_en` is high, one bit is taken from `cfg_bit` on every clock. The load has no back-pressure: the source supplies a bit on each enabled cycle and the block always accepts it. During loading every pad enable is forced low.

A pad's value reaches the array through a feedback register. A function wider than seven terms can therefore be split: one output computes a partial sum, and a second output consumes it through its pad one clock later.

Top module: `sop_array`

## Requirements
- R1: After reset, every fuse is connected, so every product term is 0. Until the first load, `drv_en` is 0 and `drv_val` is all ones.
- R2: On each clock with `cfg_en` high, the chain shifts one place toward index 0 and `cfg_bit` enters at index 2047. After 2048 such clocks, the first bit sent sits at index 0. Fuse index = (output*8 + term)*32 + literal. Literal 2j is the true form of array input j and literal 2j+1 is its complement. Array inputs 0..9 are `in_pins[0..9]` and array inputs 10..15 are pads 0..5.
- R3: While `cfg_en` is high, `drv_en` is all zero.
- R4: A product term with no connected literal evaluates to 1.
- R5: A product term that connects both forms of one input evaluates to 0.
- R6: `drv_val[k]` is the inverse of the OR of terms 0..6 of output k.
- R7: `drv_en[k]` equals term 7 of output k (outside loading).
- R8: Array input 10+k equals the registered `drv_val[k]` from the previous clock if `drv_en[k]` was high on that clock. Otherwise it equals `io_in[k]` on the current clock.
- R9: The fuses of one output affect no other output; terms are never shared.
- R10: With `cfg_en` low, the fuse map does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Fuse-chain shift enable; disables all pads |
| cfg_bit | input | 1 | Serial fuse data, first bit lands at index 0 |
| in_pins | input | 10 | Dedicated array inputs 0..9 |
| io_in | input | 6 | Externally driven level on pads 0..5 |
| drv_val | output | 8 | Active-low pad values; bits 0..5 are bidirectional pads, bits 6..7 are output-only pads |
| drv_en | output | 8 | Pad output enables, same order as drv_val |

## Verification
A single wrong fuse bit is invisible until an input pattern makes its product term the deciding one. The bench therefore drives broad random input sweeps over two fuse maps. A misaligned shift shows only after a full load, and it corrupts many outputs at once. A fault in the feedback registers shows one clock after the feeding pad changes, and only on outputs that read that pad. A chained-output pattern and a pad-release pattern target these cases.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // registered view of one driven pad, fed back into the array
  typedef struct packed {
    logic en;
    logic val;
  } pad_fb_t;
endpackage

// File: rtl/sop_fuse_chain.sv
module sop_fuse_chain #(
  parameter int W = 2048
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] fuse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fuse <= '1;
    else if (shift) fuse <= {din, fuse[W-1:1]};
  end
endmodule

// File: rtl/sop_pterm.sv
module sop_pterm #(
  parameter int N_ARR = 16
) (
  input  logic [2*N_ARR-1:0] fuse_row,
  input  logic [N_ARR-1:0]   arr,
  output logic               term
);
  logic [N_ARR-1:0] keep;
  always_comb begin
    for (int j = 0; j < N_ARR; j++) begin
      keep[j] = (~fuse_row[2*j] | arr[j]) & (~fuse_row[2*j+1] | ~arr[j]);
    end
  end
  assign term = &keep;
endmodule

// File: rtl/sop_macro.sv
module sop_macro #(
  parameter int N_ARR = 16,
  parameter int TPO   = 8
) (
  input  logic [TPO*2*N_ARR-1:0] fuse_blk,
  input  logic [N_ARR-1:0]       arr,
  output logic                   sum_n,
  output logic                   oe_term
);
  localparam int ROW = 2 * N_ARR;
  logic [TPO-1:0] terms;

  for (genvar t = 0; t < TPO; t++) begin : g_term
    sop_pterm #(.N_ARR(N_ARR)) u_term (
      .fuse_row(fuse_blk[t*ROW +: ROW]),
      .arr     (arr),
      .term    (terms[t])
    );
  end

  assign sum_n   = ~|terms[TPO-2:0];
  assign oe_term = terms[TPO-1];
endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int IN_ONLY  = 10,
  parameter int BIDIR    = 6,
  parameter int OUT_ONLY = 2,
  parameter int OR_TERMS = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_en,
  input  logic                      cfg_bit,
  input  logic [IN_ONLY-1:0]        in_pins,
  input  logic [BIDIR-1:0]          io_in,
  output logic [BIDIR+OUT_ONLY-1:0] drv_val,
  output logic [BIDIR+OUT_ONLY-1:0] drv_en
);
  import sop_pkg::*;

  localparam int N_ARR  = IN_ONLY + BIDIR;
  localparam int N_OUT  = BIDIR + OUT_ONLY;
  localparam int TPO    = OR_TERMS + 1;
  localparam int N_LIT  = 2 * N_ARR;
  localparam int BLK    = TPO * N_LIT;
  localparam int FUSE_W = N_OUT * BLK;

  logic [FUSE_W-1:0] fuse_q;
  pad_fb_t [BIDIR-1:0] fb_q;
  logic [BIDIR-1:0] pad_view;
  logic [N_ARR-1:0] arr;
  logic [N_OUT-1:0] sum_n;
  logic [N_OUT-1:0] oe_term;

  sop_fuse_chain #(.W(FUSE_W)) u_chain (
    .clk  (clk),
    .rst_n(rst_n),
    .shift(cfg_en),
    .din  (cfg_bit),
    .fuse (fuse_q)
  );

  // feedback taken one clock late so no combinational loop forms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q <= '0;
    end else begin
      for (int k = 0; k < BIDIR; k++) begin
        fb_q[k].en  <= drv_en[k];
        fb_q[k].val <= drv_val[k];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < BIDIR; k++) begin
      pad_view[k] = fb_q[k].en ? fb_q[k].val : io_in[k];
    end
  end

  assign arr = {pad_view, in_pins};

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    sop_macro #(.N_ARR(N_ARR), .TPO(TPO)) u_macro (
      .fuse_blk(fuse_q[o*BLK +: BLK]),
      .arr     (arr),
      .sum_n   (sum_n[o]),
      .oe_term (oe_term[o])
    );
  end

  assign drv_val = sum_n;
  assign drv_en  = oe_term & ~{N_OUT{cfg_en}};
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int N_OUT = 8,
  parameter int FW    = 2048
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_bit,
  input logic [N_OUT-1:0] drv_val,
  input logic [N_OUT-1:0] drv_en,
  input logic [FW-1:0]    fuse
);
  logic seen_load;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_load <= 1'b0;
    else if (cfg_en) seen_load <= 1'b1;
  end

  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_load && !cfg_en) |-> (drv_en == '0 && drv_val == '1)); // R1
  AST_FUSE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (fuse[FW-1] == $past(cfg_bit) && fuse[0] == $past(fuse[1]))); // R2
  AST_LOAD_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> drv_en == '0); // R3
  AST_FUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(fuse)); // R10
endmodule

bind sop_array sop_array_chk #(.N_OUT(N_OUT), .FW(FUSE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cfg_en (cfg_en),
  .cfg_bit(cfg_bit),
  .drv_val(drv_val),
  .drv_en (drv_en),
  .fuse   (fuse_q)
);

// File: tb/test_sop_array.sv
module test_sop_array;
  localparam int P = 10;
  localparam int NF = 2048;

  logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_bit = 1'b0;
  logic [9:0] in_pins = '0;
  logic [5:0] io_in = '0;
  logic [7:0] drv_val, drv_en;
  int total = 0, bad = 0;

  bit fm [0:NF-1];
  bit ld [0:NF-1];
  logic [5:0] m_fb_en, m_fb_val;

  sop_array i_sop_array (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .in_pins(in_pins), .io_in(io_in), .drv_val(drv_val), .drv_en(drv_en));

  always #(P/2) clk = ~clk;

  function automatic logic [15:0] m_arr();
    logic [15:0] a;
    a[9:0] = in_pins;
    for (int k = 0; k < 6; k++) a[10+k] = m_fb_en[k] ? m_fb_val[k] : io_in[k];
    return a;
  endfunction

  function automatic bit m_term(int o, int t, logic [15:0] a);
    int b = (o*8 + t) * 32;
    bit r = 1'b1;
    for (int j = 0; j < 16; j++) begin
      if (fm[b+2*j] && !a[j]) r = 1'b0;
      if (fm[b+2*j+1] && a[j]) r = 1'b0;
    end
    return r;
  endfunction

  task automatic m_eval(output logic [7:0] v, output logic [7:0] e);
    logic [15:0] a = m_arr();
    for (int o = 0; o < 8; o++) begin
      bit s = 1'b0;
      for (int t = 0; t < 7; t++) s = s | m_term(o, t, a);
      v[o] = ~s;
      e[o] = m_term(o, 7, a) && !cfg_en;
    end
  endtask

  // reference state update
  always @(posedge clk) begin
    logic [7:0] v, e;
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) fm[i] = 1'b1;
      m_fb_en = '0;
      m_fb_val = '0;
    end else begin
      m_eval(v, e);
      m_fb_en = e[5:0];
      m_fb_val = v[5:0];
      if (cfg_en) begin
        for (int i = 0; i < NF-1; i++) fm[i] = fm[i+1];
        fm[NF-1] = cfg_bit;
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R6 values, R7 enables)
  always @(negedge clk) begin
    logic [7:0] v, e;
    #(P/4);
    if (rst_n) begin
      m_eval(v, e);
      chk("R6", drv_val, v);
      chk("R7", drv_en, e);
    end
  end

  task automatic term_off(int o, int t);
    for (int l = 0; l < 32; l++) ld[(o*8+t)*32+l] = 1'b1;
  endtask
  task automatic term_empty(int o, int t);
    for (int l = 0; l < 32; l++) ld[(o*8+t)*32+l] = 1'b0;
  endtask
  task automatic lit_on(int o, int t, int l);
    ld[(o*8+t)*32+l] = 1'b1;
  endtask

  task automatic load_map();
    for (int i = 0; i < NF; i++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_bit = ld[i];
      if (i == 700) begin
        #(P/4);
        chk("R3", drv_en, 8'h00);
      end
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #(P/4 + 1);
  endtask

  initial begin
    #(P*150000);
    total++;
    bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    chk("R1", drv_en, 8'h00);
    chk("R1", drv_val, 8'hFF);

    // directed map
    for (int o = 0; o < 8; o++)
      for (int t = 0; t < 8; t++) term_off(o, t);
    term_empty(0, 0); lit_on(0, 0, 0); lit_on(0, 0, 3); term_empty(0, 7);
    term_empty(1, 0); lit_on(1, 0, 4); lit_on(1, 0, 5);
    term_empty(1, 7); lit_on(1, 7, 6);
    term_empty(2, 0); term_empty(2, 7);
    term_empty(3, 0); lit_on(3, 0, 8); term_empty(3, 7);
    term_empty(4, 0); lit_on(4, 0, 26); term_empty(4, 7);
    term_empty(5, 0); lit_on(5, 0, 22); term_empty(5, 7);
    term_empty(6, 0); lit_on(6, 0, 30); term_empty(6, 7);
    load_map();

    in_pins = 10'b0000000001; step(1);
    chk("R6", {7'b0, drv_val[0]}, 8'h00);
    in_pins = 10'b0000000011; step(1);
    chk("R6", {7'b0, drv_val[0]}, 8'h01);
    in_pins = 10'b0000000100; step(1);
    chk("R5", {7'b0, drv_val[1]}, 8'h01);
    chk("R4", {6'b0, drv_en[2], drv_val[2]}, 8'h02);
    in_pins = 10'b0000001000; step(1);
    chk("R7", {7'b0, drv_en[1]}, 8'h01);
    in_pins = 10'b0000010000; step(2);
    chk("R8", {7'b0, drv_val[4]}, 8'h01);
    in_pins = 10'b0000000000; step(2);
    chk("R8", {7'b0, drv_val[4]}, 8'h00);
    io_in = 6'b000010; step(2);
    chk("R8", {7'b0, drv_val[5]}, 8'h00);
    io_in = 6'b000000; step(1);
    chk("R8", {7'b0, drv_val[5]}, 8'h01);
    chk("R9", {6'b0, drv_en[7], drv_val[7]}, 8'h01);

    // random sweep over the directed map (R10: map held)
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      in_pins = 10'($urandom);
      io_in = 6'($urandom);
    end

    // random map, bias toward sparse terms so outputs move
    for (int i = 0; i < NF; i++) ld[i] = (($urandom % 8) == 0);
    load_map();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      in_pins = 10'($urandom);
      io_in = 6'($urandom);
    end
    step(1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule